// File: doc/BRIEF.md
# Two-Stage Cascaded Watchdog Timer

This block supervises a small microcontroller. Two 8-bit down-counters sit in series: a low stage and a high stage. When the high stage runs out, the block asks for a chip-level reset. The counters advance only on a prescaled tick, which arrives as a clock enable at one sixteenth of the selected oscillator rate. A single control register drives the whole block:

- A write starts the watchdog and reloads both counters.
- Bit 7 selects the clock for the high stage. At 0 the high stage counts low-stage underflows. At 1 it counts the prescaled tick directly.
- Bit 6 disables the stop instruction. Once software sets it, software cannot clear it. While it is set, a stop instruction turns into a reset request.

The control logic is a three-state machine:

- WD_IDLE: the block is stopped. The counters hold 0xFF and do not count. Transition T_START (any register write) leads to WD_RUN.
- WD_RUN: the counters decrement on ticks. A register write (T_RELOAD) stays in WD_RUN and reloads both counters. Transition T_TRIP leads to WD_TRIP. It is taken on a high-stage underflow, or on a stop pulse while bit 6 is set.
- WD_TRIP: this state lasts one cycle and holds the reset request high. The counters and both control bits are already back at their reset values. The state then leaves by T_REARM (back to WD_IDLE), or by T_START if a write arrives in that cycle.

Top module: `wdog_cascade`

## Requirements
- R1: After the synchronous reset `rst`, the block is stopped. Both counters hold 0xFF, bits 7 and 6 read 0, and `rst_req_o` is 0. Ticks and stop pulses have no effect until the first register write.
- R2: Every register write loads both counters with 0xFF and leaves the block counting, whatever value is written and whether the block was stopped or running.
- R3: While counting, the low stage decrements by one on every cycle with `tick_i` high. When it decrements from 0x00, it wraps to 0xFF and produces one underflow.
- R4: With bit 7 = 0, the high stage decrements once per low-stage underflow. The 65536th tick after a write causes a timeout.
- R5: With bit 7 = 1, the high stage decrements on every tick. The 256th tick after a write causes a timeout, and tick 255 does not.
- R6: A timeout or stop trip raises `rst_req_o` for exactly one cycle, in the cycle after the triggering clock edge. After that the block is stopped again, with counters at 0xFF and bits 7 and 6 at 0.
- R7: Writing 1 to bit 6 sets it. A later write with bit 6 = 0 leaves it set. Only `rst` or a trip clears it.
- R8: A `stop_exec_i` pulse while bit 6 is 1 causes a trip. While bit 6 is 0, the pulse is ignored and counting continues unchanged.
- R9: While `rd_en_i` is high, `rd_data_o` returns bit 7 in position 7, bit 6 in position 6, and high-stage counter bits 7:2 in positions 5:0. While `rd_en_i` is low, `rd_data_o` is 0.
- R10: Priority order: a stop trip beats a write in the same cycle, and a write beats a tick in the same cycle (the reload wins and no decrement takes place).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescaled count enable (oscillator divided by 16) |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_en_i | input | 1 | Control register read enable |
| stop_exec_i | input | 1 | Pulse: a stop instruction is executing |
| rd_data_o | output | 8 | Control register read data |
| rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
Read data depends combinationally on registered state. A write, tick or stop presented before clock edge k is therefore visible on `rd_data_o` just after edge k. `rst_req_o` comes from the state register, so it is high for exactly the cycle that follows the edge carrying the 256th tick (fast mode), the 65536th tick (slow mode) or the stop pulse.

The bench drives every input at a falling edge and applies the same inputs to a behavioural integer model. It then compares both outputs at the next falling edge, so every result is sampled in the cycle it is due. Literal checks pin down the exact tick of each timeout without relying on the model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int STAGE_W = 8;
    localparam int REG_W   = 8;
    localparam int SRC_BIT = 7;
    localparam int DIS_BIT = 6;
    localparam int HI_VIEW = REG_W - 2;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_stage.sv
module wdog_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            cnt_q <= '1;
        end else if (dec_i) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign uf_o  = dec_i && (cnt_q == '0);

    // R2: a reload request leaves the stage full
    a_r2_reload_full: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == '1));

    // R3: one step down per enabled tick, wrapping through zero
    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic wr_en_i,
    input  logic wr_src_i,
    input  logic wr_dis_i,
    input  logic stop_i,
    input  logic lo_uf_i,
    input  logic hi_uf_i,
    output logic load_o,
    output logic lo_dec_o,
    output logic hi_dec_o,
    output logic src_o,
    output logic dis_o,
    output logic rst_req_o
);
    wd_state_e state_q, state_d;
    logic      src_q, dis_q;
    logic      stop_trip, to_trip, running;

    assign running   = (state_q == WD_RUN);
    assign stop_trip = stop_i && dis_q;
    assign to_trip   = stop_trip || hi_uf_i;

    // counter controls: a write or stop trip suppresses any decrement
    always_comb begin
        lo_dec_o = running && tick_i && !wr_en_i && !stop_trip;
        hi_dec_o = running && !wr_en_i && !stop_trip &&
                   (src_q ? tick_i : lo_uf_i);
        load_o   = wr_en_i || to_trip;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (wr_en_i) state_d = WD_RUN;            // T_START
            WD_RUN: begin
                if (to_trip)      state_d = WD_TRIP;           // T_TRIP
                else              state_d = WD_RUN;            // T_RELOAD / count
            end
            WD_TRIP: begin
                if (wr_en_i)      state_d = WD_RUN;            // T_START
                else              state_d = WD_IDLE;           // T_REARM
            end
            default:              state_d = WD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= WD_IDLE;
        else     state_q <= state_d;
    end

    // control bits
    always_ff @(posedge clk) begin
        if (rst || to_trip) begin
            src_q <= 1'b0;
            dis_q <= 1'b0;
        end else if (wr_en_i) begin
            src_q <= wr_src_i;
            dis_q <= dis_q | wr_dis_i;
        end
    end

    // outputs
    always_comb begin
        rst_req_o = (state_q == WD_TRIP);
        src_o     = src_q;
        dis_o     = dis_q;
    end

    // R6: the reset request never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    // R7: the disable bit survives anything except a trip
    a_r7_sticky_dis: assert property (@(posedge clk) disable iff (rst)
        (dis_q && !stop_i && !hi_uf_i) |=> dis_q);

    // R8: stop with the disable bit set requests a reset
    a_r8_stop_trips: assert property (@(posedge clk) disable iff (rst)
        (stop_i && dis_q) |=> rst_req_o);

    // R4: slow mode advances the high stage only on low-stage underflow
    a_r4_slow_gate: assert property (@(posedge clk) disable iff (rst)
        (hi_dec_o && !src_q) |-> lo_uf_i);
endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic             stop_exec_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             rst_req_o
);
    logic               load, lo_dec, hi_dec, lo_uf, hi_uf;
    logic               src, dis;
    logic [STAGE_W-1:0] lo_cnt, hi_cnt;

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_src_i  (wr_data_i[SRC_BIT]),
        .wr_dis_i  (wr_data_i[DIS_BIT]),
        .stop_i    (stop_exec_i),
        .lo_uf_i   (lo_uf),
        .hi_uf_i   (hi_uf),
        .load_o    (load),
        .lo_dec_o  (lo_dec),
        .hi_dec_o  (hi_dec),
        .src_o     (src),
        .dis_o     (dis),
        .rst_req_o (rst_req_o)
    );

    wdog_stage #(.W(STAGE_W)) u_lo (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .dec_i  (lo_dec),
        .cnt_o  (lo_cnt),
        .uf_o   (lo_uf)
    );

    wdog_stage #(.W(STAGE_W)) u_hi (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .dec_i  (hi_dec),
        .cnt_o  (hi_cnt),
        .uf_o   (hi_uf)
    );

    always_comb begin
        if (rd_en_i)
            rd_data_o = {src, dis, hi_cnt[STAGE_W-1 -: HI_VIEW]};
        else
            rd_data_o = '0;
    end
endmodule

// File: tb/sim_wdog_cascade.sv
module sim_wdog_cascade;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b1, stop_exec_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       rst_req_o;

    int checks = 0;
    int errors = 0;

    // behavioural model
    int m_lo = 255, m_hi = 255, m_st = 0;
    bit m_src = 0, m_dis = 0;

    always #5 clk = ~clk;

    wdog_cascade u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .stop_exec_i(stop_exec_i),
        .rd_data_o(rd_data_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_step(bit wr, logic [7:0] d, bit tk, bit stp);
        bit st_trip, huf, luf;
        st_trip = stp && m_dis;
        huf = 0;
        if (m_st == 1 && !wr && !st_trip && tk) begin
            luf  = (m_lo == 0);
            m_lo = (m_lo + 255) % 256;
            if (m_src || luf) begin
                huf  = (m_hi == 0);
                m_hi = (m_hi + 255) % 256;
            end
        end
        if (st_trip || huf) begin
            m_st = 2; m_lo = 255; m_hi = 255; m_src = 0; m_dis = 0;
        end else if (wr) begin
            m_st = 1; m_lo = 255; m_hi = 255; m_src = d[7]; m_dis = m_dis | d[6];
        end else if (m_st == 2) begin
            m_st = 0;
        end
    endfunction

    // one cycle: drive at falling edge, compare at next falling edge
    task automatic cyc(input bit wr, input logic [7:0] d, input bit tk,
                       input bit stp, input bit rd, input string tag);
        int exp_rd;
        wr_en_i = wr; wr_data_i = d; tick_i = tk; stop_exec_i = stp; rd_en_i = rd;
        model_step(wr, d, tk, stp);
        @(posedge clk);
        @(negedge clk);
        exp_rd = rd ? ((int'(m_src) << 7) | (int'(m_dis) << 6) | (m_hi >> 2)) : 0;
        check({tag, " rd_data"}, rd_data_o, exp_rd);
        check({tag, " rst_req"}, rst_req_o, (m_st == 2) ? 1 : 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en_i = 0; tick_i = 0; stop_exec_i = 0; rd_en_i = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_lo = 255; m_hi = 255; m_st = 0; m_src = 0; m_dis = 0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        @(negedge clk);
        do_reset();

        // R1: reset state, then ticks and stop pulses ignored while stopped
        check("R1 reset read", rd_data_o, 8'h3F);
        check("R1 reset req", rst_req_o, 0);
        for (int i = 0; i < 300; i++) cyc(0, 8'h00, 1, i == 7, 1, "R1");
        check("R1 idle read", rd_data_o, 8'h3F);

        // R9: read gating
        cyc(0, 8'h00, 0, 0, 0, "R9");
        check("R9 rd_en low", rd_data_o, 0);

        // R5: fast mode, timeout on tick 256 exactly
        cyc(1, 8'h80, 0, 0, 1, "R2");
        check("R2 start read", rd_data_o, 8'hBF);
        seen = 0;
        for (int i = 1; i <= 255; i++) begin
            cyc(0, 8'h00, 1, 0, 1, "R5");
            if (rst_req_o) seen++;
            if (i == 4) check("R9 hi view", rd_data_o, 8'hBE);
        end
        check("R5 no req by tick 255", seen, 0);
        cyc(0, 8'h00, 1, 0, 1, "R5");
        check("R5 req at tick 256", rst_req_o, 1);
        cyc(0, 8'h00, 1, 0, 1, "R6");
        check("R6 pulse one cycle", rst_req_o, 0);
        check("R6 stopped after trip", rd_data_o, 8'h3F);

        // R10: write beats tick; reload mid-run (R2)
        cyc(1, 8'h80, 0, 0, 1, "R2");
        for (int i = 0; i < 100; i++) cyc(0, 8'h00, 1, 0, 1, "R3");
        cyc(1, 8'h80, 1, 0, 1, "R10");
        check("R10 write wins over tick", rd_data_o, 8'hBF);

        // R7: sticky disable bit
        cyc(1, 8'h40, 0, 0, 1, "R7");
        cyc(1, 8'h00, 0, 0, 1, "R7");
        check("R7 bit6 kept", rd_data_o, 8'h7F);
        for (int i = 0; i < 20; i++) cyc(0, 8'h00, 1, 0, 1, "R3");

        // R8 + R10: stop with bit6 set trips, even with a write in the same cycle
        cyc(1, 8'h00, 1, 1, 1, "R10");
        check("R8 stop trips", rst_req_o, 1);
        cyc(0, 8'h00, 0, 0, 1, "R6");
        check("R7 cleared by trip", rd_data_o, 8'h3F);

        // R8: stop ignored with bit6 clear
        cyc(1, 8'h80, 0, 0, 1, "R8");
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1, i == 5, 1, "R8");
        check("R8 stop ignored", rd_data_o, 8'hBD);

        // R7: rst clears bit6
        cyc(1, 8'h40, 0, 0, 1, "R7");
        do_reset();
        check("R7 rst clears", rd_data_o, 8'h3F);

        // R4: slow mode, timeout on tick 65536; idle gaps between ticks
        cyc(1, 8'h00, 0, 0, 1, "R4");
        seen = 0;
        for (int i = 1; i <= 65535; i++) begin
            cyc(0, 8'h00, 1, 0, 1, "R4");
            if (rst_req_o) seen++;
            if (i == 256) check("R3 low underflow steps high", rd_data_o, 8'h3F);
            if (i == 1024) check("R4 hi after 4 underflows", rd_data_o, 8'h3E);
            if (i == 3000) cyc(0, 8'h00, 0, 0, 1, "R3");
        end
        check("R4 no req by tick 65535", seen, 0);
        cyc(0, 8'h00, 1, 0, 1, "R4");
        check("R4 req at tick 65536", rst_req_o, 1);
        cyc(0, 8'h00, 0, 0, 1, "R6");
        check("R6 pulse ends", rst_req_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule